// File: doc/BRIEF.md
# Dual-Output Phase-Frequency Detector

This block compares two pulse trains inside a frequency synthesiser loop. One train comes from the divided reference and the other from the divided VCO. Both are sampled on the block clock. A rising edge on either sampled train sets a flag for that side. Once both flags are set, they stay set together for a fixed minimum number of clock cycles and are then cleared together. The flag that leads therefore shows, in width, the phase or frequency error.

The flags are presented in two forms. The first is a single-ended error line, given as a drive enable and a data value. It is driven only while exactly one flag is set. It drives low when the VCO side is ahead and high when the reference side is ahead. The second form is a pair of active-low lines, one for each side. When the inputs coincide, both active-low lines drop together for the minimum hold, so the charge pump behind them is never left with a dead zone.

Top module: `pfd_dual_out`

## Requirements
- R1: While reset is asserted and after it is released with no input edges, `pd_oe` is 0 and both `ref_up_n` and `vco_up_n` are 1.
- R2: A 0-to-1 change of an input, sampled through SYNC_STAGES flops, sets that side's flag. The active-low line of that side goes to 0 SYNC_STAGES+1 clock edges after the change is first clocked.
- R3: When the VCO edge arrives first, `vco_up_n` is 0, `ref_up_n` stays 1, and the single-ended line is driven (`pd_oe`=1) with `pd_val`=0 until the reference edge arrives.
- R4: When the reference edge arrives first, `ref_up_n` is 0, `vco_up_n` stays 1, and `pd_oe`=1 with `pd_val`=1 until the VCO edge arrives.
- R5: When both edges are seen in the same cycle, both active-low lines are 0 for exactly CLR_CYCLES cycles, `pd_oe` stays 0, and both lines then return to 1.
- R6: Once both flags are set, they stay set for CLR_CYCLES cycles and are then cleared in the same cycle.
- R7: An input held at 1 sets its flag only once. Only 0-to-1 changes count as events.
- R8: A rising edge seen in the cycle in which both flags clear is not lost. That side's flag is set again in the next cycle.
- R9: `pd_oe` is 1 exactly when one flag is set and the other is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Divided reference pulse train |
| vco_in | input | 1 | Divided VCO pulse train |
| pd_oe | output | 1 | Drive enable of the single-ended error line (0 = high impedance) |
| pd_val | output | 1 | Value of the single-ended line while driven |
| ref_up_n | output | 1 | Active-low reference-side error pulse |
| vco_up_n | output | 1 | Active-low VCO-side error pulse |

## Verification
The bench builds the block with SYNC_STAGES=2 and CLR_CYCLES=3. With a three-cycle hold, an edge can be placed in the clear cycle itself, which exercises the re-set path. A hold of 3 also tells a correct hold length apart from one that is off by one in either direction. With the two-stage sampler the latency is a fixed three edges, so the scoreboard can schedule each expected output vector against a cycle count. That covers leads, lags, coincidence, several VCO pulses to one reference pulse, and held-high inputs.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // True on the last cycle of a hold that must last len cycles.
  function automatic logic hold_last(input int unsigned age, input int unsigned len);
    return (age + 1) >= len;
  endfunction

  // The single-ended line is driven only when the two flags disagree.
  function automatic logic err_enable(input logic ref_set, input logic vco_set);
    return ref_set ^ vco_set;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  // sh[STAGES-1] is the sampled value; sh[STAGES] is its previous cycle.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pfd_flag_pair.sv
module pfd_flag_pair #(
  parameter int CLR_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic vco_rise,
  output logic ref_set,
  output logic vco_set,
  output logic both_set,
  output logic clr_fire
);
  localparam int CNT_W = (CLR_CYCLES < 2) ? 1 : $clog2(CLR_CYCLES);

  logic [CNT_W-1:0] age;

  assign both_set = ref_set & vco_set;
  assign clr_fire = both_set & pfd_pkg::hold_last(32'(age), CLR_CYCLES);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_set <= 1'b0;
      vco_set <= 1'b0;
      age     <= '0;
    end else begin
      // A new edge takes priority over the clear of the same cycle.
      ref_set <= ref_rise | (ref_set & ~clr_fire);
      vco_set <= vco_rise | (vco_set & ~clr_fire);
      if (!both_set || clr_fire) age <= '0;
      else                       age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive (
  input  logic ref_set,
  input  logic vco_set,
  output logic pd_oe,
  output logic pd_val,
  output logic ref_up_n,
  output logic vco_up_n
);
  always_comb begin
    pd_oe    = pfd_pkg::err_enable(ref_set, vco_set);
    pd_val   = ref_set;
    ref_up_n = ~ref_set;
    vco_up_n = ~vco_set;
  end
endmodule

// File: rtl/pfd_dual_out.sv
module pfd_dual_out #(
  parameter int SYNC_STAGES = 2,
  parameter int CLR_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic vco_in,
  output logic pd_oe,
  output logic pd_val,
  output logic ref_up_n,
  output logic vco_up_n
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] rise_v;
  logic ref_rise, vco_rise;
  logic ref_set, vco_set, both_set, clr_fire;

  assign raw_in = {vco_in, ref_in};

  for (genvar g = 0; g < NCH; g++) begin : g_sync
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw_in[g]),
      .rise(rise_v[g])
    );
  end

  assign ref_rise = rise_v[0];
  assign vco_rise = rise_v[1];

  pfd_flag_pair #(.CLR_CYCLES(CLR_CYCLES)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .ref_rise(ref_rise),
    .vco_rise(vco_rise),
    .ref_set (ref_set),
    .vco_set (vco_set),
    .both_set(both_set),
    .clr_fire(clr_fire)
  );

  pfd_drive u_drive (
    .ref_set (ref_set),
    .vco_set (vco_set),
    .pd_oe   (pd_oe),
    .pd_val  (pd_val),
    .ref_up_n(ref_up_n),
    .vco_up_n(vco_up_n)
  );
endmodule

// File: rtl/pfd_dual_out_chk.sv
module pfd_dual_out_chk #(
  parameter int CLR_CYCLES = 2
) (
  input logic clk,
  input logic rst,
  input logic ref_rise,
  input logic vco_rise,
  input logic clr_fire,
  input logic pd_oe,
  input logic pd_val,
  input logic ref_up_n,
  input logic vco_up_n
);
  logic both_low;
  assign both_low = ~ref_up_n & ~vco_up_n;

  p_edge_sets_ref_r2: assert property (@(posedge clk) disable iff (rst)
    ref_rise |=> !ref_up_n);

  p_edge_sets_vco_r2: assert property (@(posedge clk) disable iff (rst)
    vco_rise |=> !vco_up_n);

  p_vco_ahead_low_r3: assert property (@(posedge clk) disable iff (rst)
    (pd_oe && !vco_up_n) |-> !pd_val);

  p_ref_ahead_high_r4: assert property (@(posedge clk) disable iff (rst)
    (pd_oe && !ref_up_n) |-> pd_val);

  p_oe_one_side_r9: assert property (@(posedge clk) disable iff (rst)
    pd_oe |-> (ref_up_n != vco_up_n));

  p_clear_ref_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_fire && !ref_rise) |=> ref_up_n);

  p_clear_vco_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_fire && !vco_rise) |=> vco_up_n);

  p_keep_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_fire && ref_rise) |=> !ref_up_n);

  if (CLR_CYCLES >= 2) begin : g_min
    p_min_hold_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(both_low) |=> both_low);
  end
endmodule

bind pfd_dual_out pfd_dual_out_chk #(.CLR_CYCLES(CLR_CYCLES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ref_rise(ref_rise),
  .vco_rise(vco_rise),
  .clr_fire(clr_fire),
  .pd_oe   (pd_oe),
  .pd_val  (pd_val),
  .ref_up_n(ref_up_n),
  .vco_up_n(vco_up_n)
);

// File: tb/pfd_dual_out_bench.sv
module pfd_dual_out_bench;
  localparam int SYNC = 2;
  localparam int HOLD = 3;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic vco_in = 1'b0;
  logic pd_oe, pd_val, ref_up_n, vco_up_n;

  pfd_dual_out #(.SYNC_STAGES(SYNC), .CLR_CYCLES(HOLD)) u_pfd_dual_out (
    .clk(clk), .rst(rst), .ref_in(ref_in), .vco_in(vco_in),
    .pd_oe(pd_oe), .pd_val(pd_val), .ref_up_n(ref_up_n), .vco_up_n(vco_up_n)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    logic [3:0] exp;   // {oe, val, ref_up_n, vco_up_n}
    string      tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  // Bench model state: which side is pending and how long both were pending.
  bit prev_r = 0, prev_v = 0;
  bit pend_r = 0, pend_v = 0;
  int both_len = 0;

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d got=%b expected=%b", tag, cyc, got, exp);
    end
  endtask

  // Drive one cycle of input and schedule the output it must produce.
  task automatic step(input bit r, input bit v);
    bit er, ev, done;
    item_t it;
    @(posedge clk); #2;
    ref_in = r; vco_in = v;
    er = r && !prev_r;
    ev = v && !prev_v;
    prev_r = r; prev_v = v;
    done = pend_r && pend_v && (both_len == HOLD - 1);
    if (pend_r && pend_v && !done) both_len++;
    else both_len = 0;
    pend_r = er || (pend_r && !done);
    pend_v = ev || (pend_v && !done);
    it.due = cyc + LAT;
    it.exp = {pend_r != pend_v, pend_r, !pend_r, !pend_v};
    it.tag = cur_tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(prev_r, prev_v);
  endtask

  // Monitor: compare scheduled items in the cycle they fall due.
  always @(negedge clk) begin
    if (!rst && sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, {pd_oe, pd_val, ref_up_n, vco_up_n}, it.exp);
    end
  end

  bit finished = 0;
  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs while reset is held.
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {pd_oe, pd_val, ref_up_n, vco_up_n}, 4'b0011);
    @(posedge clk); #2; rst = 1'b0;
    @(negedge clk);
    check("R1", {pd_oe, ref_up_n, vco_up_n}, 3'b011);
    cur_tag = "R1"; idle(4);

    // R3: VCO edge leads the reference edge by four cycles.
    cur_tag = "R3";
    step(0, 1); step(0, 0); idle(2); step(1, 0); step(0, 0); idle(6);

    // R4: reference edge leads the VCO edge by three cycles.
    cur_tag = "R4";
    step(1, 0); step(0, 0); idle(1); step(0, 1); step(0, 0); idle(6);

    // R5: coincident edges give the minimum joint pulse only.
    cur_tag = "R5";
    step(1, 1); step(0, 0); idle(6);

    // R2: single reference edge alone, then a late VCO edge.
    cur_tag = "R2";
    step(1, 0); step(0, 0); idle(5); step(0, 1); step(0, 0); idle(6);

    // R7: inputs held high create one event only.
    cur_tag = "R7";
    step(1, 0); idle(8); step(1, 1); idle(8); step(0, 0); idle(5);

    // R8: reference edge in the clear cycle of a coincident pair.
    cur_tag = "R8";
    step(1, 1); step(0, 0); step(0, 0); step(1, 0); step(0, 0); idle(4);
    step(0, 1); step(0, 0); idle(6);

    // R6: VCO runs faster; several VCO pulses per reference pulse.
    cur_tag = "R6";
    for (int k = 0; k < 4; k++) begin
      step(0, 1); step(0, 0); step(0, 0);
      if (k == 3) begin step(1, 0); step(0, 0); end
    end
    idle(8);

    // R9: alternating leads back to back.
    cur_tag = "R9";
    for (int k = 0; k < 3; k++) begin
      step(1, 0); step(0, 1); step(0, 0); idle(4);
      step(0, 1); step(1, 0); step(0, 0); idle(4);
    end

    cur_tag = "R1"; idle(LAT + 2);
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule